// File: doc/BRIEF.md
# Four-Output PWM Generator with Fault Shutdown

The block produces pulse-width modulated drive for up to four output pins, named A, B, C and D, from a single period timebase. A prescaled counter runs from zero up to an 8-bit period limit. A 10-bit duty value is compared against the counter's fine position, which gives four duty steps for each period count. A steering field routes the modulated waveform onto the pins. It can drive one pin alone, drive a complementary half-bridge pair with programmable dead time, or drive a full bridge in either direction. Each pin pair has its own active-level selection.

Three fault inputs pass through a synchronizer and a per-source enable mask. When a selected fault asserts, the block enters shutdown. In shutdown the A/C pair and the B/D pair are each forced to a safe state that software chooses. Shutdown can be left by a software clear once the fault is gone, or on its own when auto-restart is enabled. In both cases the PWM drive comes back only at a period boundary. New duty and period values also take effect only at a period boundary. A one-cycle flag marks each boundary, so software can wait for it before it enables the pins.

Top module: `epwm_fault_gen`

## Requirements
- R1: After reset every output enable is low, every output value is low, the boundary flag is low and shutdown is inactive. All configuration fields reset to zero, which selects single-pin mode, active-high levels and a stopped timer.
- R2: With the timer running (register 3 bit 2), `period_flag` pulses for one cycle every (PER+1)*4*P clocks. PER is register 0. P is 1, 4 or 16 for a prescale field (register 3 bits 1:0) of 00, 01 or 1x.
- R3: In single-pin mode pin A is active for DUTY*P clocks in each period. DUTY is {register 1, register 2 bits 1:0}. A DUTY of zero never activates the pin, and a DUTY of at least 4*(PER+1) keeps it active for the whole period.
- R4: A duty or period write made in the middle of a period has no effect until the next period boundary.
- R5: The steering field (register 2 bits 3:2) selects the pin mapping. 00 modulates A only. 01 drives A modulated and B complementary. 10 holds A active and modulates D. 11 holds C active and modulates B. Any pin the mode does not use stays inactive.
- R6: Register 2 bit 4 set makes the A/C pair active-low, and bit 5 set makes the B/D pair active-low. An inactive pin sits at the opposite level.
- R7: In half-bridge mode the active edge of A and of B is delayed by DB clocks, where DB is register 4 bits 6:0. A is then active for DUTY*P-DB clocks and B for the rest of the period minus DB, and A and B are never active together.
- R8: A selected fault (register 5 bits 2:0 enable fault inputs 2:0) sets `shutdown_active`. It then forces A/C to the state in register 5 bits 4:3 and B/D to the state in bits 6:5. Code 00 drives the pin low, 01 drives it high, and 1x turns its output enable off.
- R9: A write to register 5 with bit 7 low clears shutdown only if no selected fault is present. After a clear, the forced state stays until the next period boundary. Without auto-restart, shutdown persists across boundaries.
- R10: With auto-restart (register 4 bit 7) set, shutdown stays while any selected fault is present. Once every selected fault has gone, shutdown and the forced state are released at the next period boundary.
- R11: Pin i is driven only when bit i of register 6 is set and no tri-state safe code is forcing its pair.
- R12: A fault input whose mask bit is clear has no effect on shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| fault_in | input | 3 | Asynchronous fault inputs, active high |
| pwm_out | output | 4 | Pin values, bit 0 = A to bit 3 = D |
| pwm_oe | output | 4 | Pin drive enables, bit 0 = A to bit 3 = D |
| period_flag | output | 1 | One-cycle pulse after each period boundary |
| shutdown_active | output | 1 | Shutdown status |

## Verification
The bench measures how many cycles each pin is high over exactly one period, for each steering mode, polarity pair and prescale. A design that gets the dead time or the complement wrong shows up as a count that is off by DB or mirrored. It also covers duty values of zero and past the period, where an off-by-one comparator would produce a stray one-cycle pulse or an early drop. For a mid-period duty write and for a mid-period shutdown clear, the bench samples a point where the old and new behaviour differ. A design that latches duty immediately, or releases the forced state at once, then shows the wrong level there. A software clear attempted while a fault is still present, and a fault on a masked input, must both leave shutdown unchanged.

// File: rtl/epwm_pkg.sv
package epwm_pkg;

  typedef enum logic [1:0] {
    STEER_SINGLE = 2'b00,
    STEER_HALF   = 2'b01,
    STEER_FWD    = 2'b10,
    STEER_REV    = 2'b11
  } steer_e;

  // last prescaler count before a tick: divide by 1, 4 or 16
  function automatic logic [3:0] presc_last(input logic [1:0] sel);
    case (sel)
      2'b00:   return 4'd0;
      2'b01:   return 4'd3;
      default: return 4'd15;
    endcase
  endfunction

  // active intent per pin, bit 0 = A .. bit 3 = D
  function automatic logic [3:0] steer_map(input steer_e mode, input logic raw);
    case (mode)
      STEER_SINGLE: return {3'b000, raw};
      STEER_HALF:   return {2'b00, ~raw, raw};
      STEER_FWD:    return {raw, 2'b00, 1'b1};
      default:      return {1'b0, 1'b1, raw, 1'b0};
    endcase
  endfunction

  // pin value under a safe-state code
  function automatic logic safe_level(input logic [1:0] code);
    return (code == 2'b01);
  endfunction

  // safe-state code that releases the pin driver
  function automatic logic safe_tristate(input logic [1:0] code);
    return code[1];
  endfunction

endpackage

// File: rtl/epwm_regs.sv
module epwm_regs
  import epwm_pkg::*;
#(
  parameter int PER_W  = 8,
  parameter int DB_W   = 7,
  parameter int NFAULT = 3,
  parameter int NPIN   = 4,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [PER_W-1:0]  per_reg,
  output logic [PER_W+1:0]  duty_reg,
  output steer_e            mode,
  output logic [1:0]        pol,
  output logic [1:0]        presc,
  output logic              tmr_en,
  output logic [DB_W-1:0]   db_len,
  output logic              restart_en,
  output logic [NFAULT-1:0] src_mask,
  output logic [1:0]        safe_ac,
  output logic [1:0]        safe_bd,
  output logic [NPIN-1:0]   pin_en,
  output logic              sd_clr_req
);

  localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DUTY = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_TMR  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_DB   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_SD   = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_OE   = ADDR_W'(6);

  logic [PER_W-1:0] duty_hi;
  logic [1:0]       duty_lo;

  assign duty_reg   = {duty_hi, duty_lo};
  assign sd_clr_req = wr_en && (wr_addr == A_SD) && !wr_data[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_reg    <= '0;
      duty_hi    <= '0;
      duty_lo    <= '0;
      mode       <= STEER_SINGLE;
      pol        <= '0;
      presc      <= '0;
      tmr_en     <= 1'b0;
      db_len     <= '0;
      restart_en <= 1'b0;
      src_mask   <= '0;
      safe_ac    <= '0;
      safe_bd    <= '0;
      pin_en     <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_PER:  per_reg <= wr_data[PER_W-1:0];
        A_DUTY: duty_hi <= wr_data[PER_W-1:0];
        A_CTRL: begin
          duty_lo <= wr_data[1:0];
          mode    <= steer_e'(wr_data[3:2]);
          pol     <= wr_data[5:4];
        end
        A_TMR: begin
          presc  <= wr_data[1:0];
          tmr_en <= wr_data[2];
        end
        A_DB: begin
          db_len     <= wr_data[DB_W-1:0];
          restart_en <= wr_data[DATA_W-1];
        end
        A_SD: begin
          src_mask <= wr_data[NFAULT-1:0];
          safe_ac  <= wr_data[4:3];
          safe_bd  <= wr_data[6:5];
        end
        A_OE:    pin_en <= wr_data[NPIN-1:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/epwm_timebase.sv
module epwm_timebase
  import epwm_pkg::*;
#(
  parameter int PER_W = 8,
  localparam int DUTY_W = PER_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_en,
  input  logic [1:0]        presc,
  input  logic [PER_W-1:0]  per_reg,
  input  logic [DUTY_W-1:0] duty_reg,
  output logic [DUTY_W-1:0] fine,
  output logic [PER_W-1:0]  per_act,
  output logic [DUTY_W-1:0] duty_act,
  output logic              wrap,
  output logic              raw,
  output logic              period_flag
);

  logic [3:0] ps_cnt;
  logic       tick;

  assign tick = tmr_en && (ps_cnt >= presc_last(presc));
  assign wrap = tick && (fine == {per_act, 2'b11});
  assign raw  = tmr_en && (fine < duty_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_cnt      <= '0;
      fine        <= '0;
      per_act     <= '0;
      duty_act    <= '0;
      period_flag <= 1'b0;
    end else begin
      period_flag <= wrap;
      if (!tmr_en) begin
        ps_cnt   <= '0;
        fine     <= '0;
        per_act  <= per_reg;
        duty_act <= duty_reg;
      end else begin
        ps_cnt <= tick ? '0 : ps_cnt + 1'b1;
        if (wrap) begin
          fine     <= '0;
          per_act  <= per_reg;
          duty_act <= duty_reg;
        end else if (tick) begin
          fine <= fine + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/epwm_deadband.sv
module epwm_deadband #(
  parameter int DB_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_act,
  input  logic [DB_W-1:0] dly,
  output logic            out_act
);

  logic [DB_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      out_act <= 1'b0;
    end else if (!in_act) begin
      cnt     <= '0;
      out_act <= 1'b0;
    end else if (cnt >= dly) begin
      out_act <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/epwm_fault_ctl.sv
module epwm_fault_ctl #(
  parameter int NFAULT = 3,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFAULT-1:0] fault_in,
  input  logic [NFAULT-1:0] src_mask,
  input  logic              restart_en,
  input  logic              sd_clr_req,
  input  logic              wrap,
  output logic              fault_hit,
  output logic              sd_status,
  output logic              force_safe
);

  logic [SYNC-1:0][NFAULT-1:0] sync_q;
  logic                        sd_next;
  logic                        force_next;

  assign fault_hit = |(sync_q[SYNC-1] & src_mask);

  always_comb begin
    if (fault_hit)                 sd_next = 1'b1;
    else if (sd_clr_req)           sd_next = 1'b0;
    else if (restart_en && wrap)   sd_next = 1'b0;
    else                           sd_next = sd_status;
    force_next = sd_next ? 1'b1 : (wrap ? 1'b0 : force_safe);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= '0;
      sd_status  <= 1'b0;
      force_safe <= 1'b0;
    end else begin
      sync_q     <= {sync_q[SYNC-2:0], fault_in};
      sd_status  <= sd_next;
      force_safe <= force_next;
    end
  end

endmodule

// File: rtl/epwm_fault_gen.sv
module epwm_fault_gen
  import epwm_pkg::*;
#(
  parameter int PER_W  = 8,
  parameter int DB_W   = 7,
  parameter int NFAULT = 3,
  parameter int SYNC   = 2,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  localparam int NPIN   = 4,
  localparam int DUTY_W = PER_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NFAULT-1:0] fault_in,
  output logic [NPIN-1:0]   pwm_out,
  output logic [NPIN-1:0]   pwm_oe,
  output logic              period_flag,
  output logic              shutdown_active
);

  logic [PER_W-1:0]  per_reg, per_act;
  logic [DUTY_W-1:0] duty_reg, duty_act, fine;
  steer_e            mode;
  logic [1:0]        pol, presc, safe_ac, safe_bd;
  logic              tmr_en, restart_en, sd_clr_req;
  logic [DB_W-1:0]   db_len;
  logic [NFAULT-1:0] src_mask;
  logic [NPIN-1:0]   pin_en;
  logic              wrap, raw;
  logic              fault_hit, sd_status, force_safe;
  logic [NPIN-1:0]   steer_act;
  logic [NPIN-1:0]   lane_act;

  epwm_regs #(
    .PER_W(PER_W), .DB_W(DB_W), .NFAULT(NFAULT), .NPIN(NPIN),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .per_reg(per_reg), .duty_reg(duty_reg), .mode(mode), .pol(pol), .presc(presc),
    .tmr_en(tmr_en), .db_len(db_len), .restart_en(restart_en), .src_mask(src_mask),
    .safe_ac(safe_ac), .safe_bd(safe_bd), .pin_en(pin_en), .sd_clr_req(sd_clr_req)
  );

  epwm_timebase #(.PER_W(PER_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .presc(presc),
    .per_reg(per_reg), .duty_reg(duty_reg), .fine(fine), .per_act(per_act),
    .duty_act(duty_act), .wrap(wrap), .raw(raw), .period_flag(period_flag)
  );

  epwm_fault_ctl #(.NFAULT(NFAULT), .SYNC(SYNC)) u_fault (
    .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .src_mask(src_mask),
    .restart_en(restart_en), .sd_clr_req(sd_clr_req), .wrap(wrap),
    .fault_hit(fault_hit), .sd_status(sd_status), .force_safe(force_safe)
  );

  assign steer_act       = steer_map(mode, raw);
  assign shutdown_active = sd_status;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    // pins 0 and 2 form the A/C pair, pins 1 and 3 the B/D pair
    localparam bit PAIR_AC = (i % 2 == 0);
    logic [DB_W-1:0] dly_eff;
    logic [1:0]      safe_code;
    logic            act_pol;

    // dead time only on the half-bridge pair
    assign dly_eff   = (mode == STEER_HALF && i < 2) ? db_len : '0;
    assign safe_code = PAIR_AC ? safe_ac : safe_bd;
    assign act_pol   = PAIR_AC ? pol[0] : pol[1];

    epwm_deadband #(.DB_W(DB_W)) u_db (
      .clk(clk), .rst_n(rst_n), .in_act(steer_act[i]), .dly(dly_eff),
      .out_act(lane_act[i])
    );

    assign pwm_out[i] = force_safe ? safe_level(safe_code) : (lane_act[i] ^ act_pol);
    assign pwm_oe[i]  = pin_en[i] && !(force_safe && safe_tristate(safe_code));
  end

endmodule

// File: rtl/epwm_fault_gen_chk.sv
module epwm_fault_gen_chk
  import epwm_pkg::*;
#(
  parameter int PER_W = 8,
  localparam int DUTY_W = PER_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input steer_e            mode,
  input logic [3:0]        lane_act,
  input logic              period_flag,
  input logic              tmr_en,
  input logic              wrap,
  input logic              fault_hit,
  input logic              sd_status,
  input logic              force_safe,
  input logic [DUTY_W-1:0] duty_act,
  input logic [DUTY_W-1:0] fine,
  input logic [PER_W-1:0]  per_act
);

  // R7
  halfbridge_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == STEER_HALF) |-> !(lane_act[0] && lane_act[1]));

  // R2
  flag_needs_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_flag |-> $past(tmr_en));

  // R2
  fine_within_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fine[DUTY_W-1:2] <= per_act);

  // R4
  duty_boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(duty_act) |-> $past(wrap || !tmr_en));

  // R8
  fault_enters_shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_hit |=> sd_status);

  // R8
  status_implies_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_status |-> force_safe);

  // R9
  release_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(force_safe) |-> $past(wrap));

endmodule

bind epwm_fault_gen epwm_fault_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .lane_act(lane_act),
  .period_flag(period_flag), .tmr_en(tmr_en), .wrap(wrap),
  .fault_hit(fault_hit), .sd_status(sd_status), .force_safe(force_safe),
  .duty_act(duty_act), .fine(fine), .per_act(per_act)
);

// File: tb/epwm_fault_gen_tb.sv
module epwm_fault_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] fault_in = '0;
  logic [3:0] pwm_out, pwm_oe;
  logic       period_flag, shutdown_active;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  epwm_fault_gen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fault_in(fault_in), .pwm_out(pwm_out), .pwm_oe(pwm_oe),
    .period_flag(period_flag), .shutdown_active(shutdown_active)
  );

  typedef struct packed {
    logic [7:0]  per;
    logic [9:0]  duty;
    logic [1:0]  ps;
    logic [1:0]  mode;
    logic [1:0]  pol;
    logic [6:0]  db;
    logic [15:0] t;
    logic [15:0] ea, eb, ec, ed;
  } vec_t;

  // expected high-cycle counts per pin over one period (pin value, not activity)
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'd9, 10'd13, 2'd0, 2'd0, 2'b00, 7'd0, 16'd40,  16'd13, 16'd0,  16'd0,  16'd0},
    '{8'd9, 10'd13, 2'd1, 2'd0, 2'b00, 7'd0, 16'd160, 16'd52, 16'd0,  16'd0,  16'd0},
    '{8'd4, 10'd0,  2'd0, 2'd0, 2'b00, 7'd0, 16'd20,  16'd0,  16'd0,  16'd0,  16'd0},
    '{8'd4, 10'd25, 2'd0, 2'd0, 2'b00, 7'd0, 16'd20,  16'd20, 16'd0,  16'd0,  16'd0},
    '{8'd9, 10'd13, 2'd0, 2'd1, 2'b00, 7'd3, 16'd40,  16'd10, 16'd24, 16'd0,  16'd0},
    '{8'd9, 10'd13, 2'd0, 2'd2, 2'b00, 7'd0, 16'd40,  16'd40, 16'd0,  16'd0,  16'd13},
    '{8'd9, 10'd13, 2'd0, 2'd3, 2'b00, 7'd0, 16'd40,  16'd0,  16'd13, 16'd40, 16'd0},
    '{8'd9, 10'd13, 2'd0, 2'd0, 2'b01, 7'd0, 16'd40,  16'd27, 16'd0,  16'd40, 16'd0},
    '{8'd9, 10'd20, 2'd0, 2'd1, 2'b11, 7'd2, 16'd40,  16'd22, 16'd22, 16'd40, 16'd40},
    '{8'd1, 10'd3,  2'd2, 2'd0, 2'b00, 7'd0, 16'd128, 16'd48, 16'd0,  16'd0,  16'd0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_flag();
    do @(negedge clk); while (!period_flag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pwm_oe == 4'b0000, "R1", "oe after reset", pwm_oe, 0);
    chk(pwm_out == 4'b0000, "R1", "out after reset", pwm_out, 0);
    chk(period_flag == 1'b0, "R1", "flag after reset", period_flag, 0);
    chk(shutdown_active == 1'b0, "R1", "shutdown after reset", shutdown_active, 0);

    // vector table: R2 period length, R3/R5/R6/R7 per-pin high counts
    for (int v = 0; v < NV; v++) begin
      vec_t cv;
      string tag;
      int n;
      int cnt [4];
      cv = VECS[v];
      tag = (cv.pol != 0) ? "R6" : (cv.mode == 2'd1) ? "R7" : (cv.mode != 0) ? "R5" : "R3";
      wr(3'd3, 8'h00);
      wr(3'd6, 8'h0F);
      wr(3'd0, cv.per);
      wr(3'd1, cv.duty[9:2]);
      wr(3'd2, {2'b00, cv.pol, cv.mode, cv.duty[1:0]});
      wr(3'd4, {1'b0, cv.db});
      wr(3'd3, {5'b00001, 1'b0, cv.ps} | 8'h04);
      wait_flag();
      wait_flag();
      n = 0;
      do begin @(negedge clk); n++; end while (!period_flag);
      chk(n == int'(cv.t), "R2", $sformatf("vector %0d period", v), n, cv.t);
      for (int p = 0; p < 4; p++) cnt[p] = 0;
      for (int k = 0; k < int'(cv.t); k++) begin
        @(negedge clk);
        for (int p = 0; p < 4; p++) if (pwm_out[p]) cnt[p]++;
      end
      chk(cnt[0] == int'(cv.ea), tag, $sformatf("vector %0d pin A", v), cnt[0], cv.ea);
      chk(cnt[1] == int'(cv.eb), tag, $sformatf("vector %0d pin B", v), cnt[1], cv.eb);
      chk(cnt[2] == int'(cv.ec), tag, $sformatf("vector %0d pin C", v), cnt[2], cv.ec);
      chk(cnt[3] == int'(cv.ed), tag, $sformatf("vector %0d pin D", v), cnt[3], cv.ed);
    end

    // directed: single mode, PER=9, DUTY=13, P=1
    wr(3'd3, 8'h00);
    wr(3'd0, 8'd9);
    wr(3'd1, 8'd3);
    wr(3'd2, 8'h01);
    wr(3'd4, 8'h00);
    wr(3'd3, 8'h04);

    // R11 per-pin drive enable
    wr(3'd6, 8'h05);
    chk(pwm_oe == 4'b0101, "R11", "oe follows enable bits", pwm_oe, 5);
    wr(3'd6, 8'h0F);

    // R4 mid-period duty write waits for boundary
    wait_flag();
    wait_flag();
    wr(3'd1, 8'd7);
    repeat (19) @(negedge clk);
    chk(pwm_out[0] == 1'b0, "R4", "old duty kept mid-period", pwm_out[0], 0);
    wait_flag();
    repeat (20) @(negedge clk);
    chk(pwm_out[0] == 1'b1, "R4", "new duty after boundary", pwm_out[0], 1);
    wr(3'd1, 8'd3);
    wait_flag();

    // R12 masked fault ignored: mask=001, AC safe=01, BD safe=00
    wr(3'd5, 8'h09);
    fault_in = 3'b010;
    repeat (5) @(negedge clk);
    chk(shutdown_active == 1'b0, "R12", "masked fault", shutdown_active, 0);
    fault_in = 3'b000;

    // R8 selected fault forces safe states
    fault_in = 3'b001;
    repeat (5) @(negedge clk);
    chk(shutdown_active == 1'b1, "R8", "fault sets shutdown", shutdown_active, 1);
    chk(pwm_out == 4'b0101, "R8", "safe levels A/C high B/D low", pwm_out, 5);
    chk(pwm_oe == 4'b1111, "R8", "driven safe levels keep oe", pwm_oe, 15);
    // AC safe=10 (tri-state); bit7 low is also a clear attempt while fault present
    wr(3'd5, 8'h11);
    @(negedge clk);
    chk(shutdown_active == 1'b1, "R9", "clear ignored while fault present", shutdown_active, 1);
    chk(pwm_oe == 4'b1010, "R8", "tri-state safe code drops A/C oe", pwm_oe, 10);
    chk(pwm_oe == 4'b1010, "R11", "oe masked by tri-state shutdown", pwm_oe, 10);
    wr(3'd5, 8'h01);
    @(negedge clk);
    chk(pwm_out == 4'b0000, "R8", "safe code 00 drives low", pwm_out, 0);
    fault_in = 3'b000;
    repeat (5) @(negedge clk);
    wait_flag();
    repeat (2) @(negedge clk);
    chk(shutdown_active == 1'b1, "R9", "no restart without enable", shutdown_active, 1);

    // R9 software clear, release at next boundary
    wait_flag();
    wr(3'd5, 8'h01);
    chk(shutdown_active == 1'b0, "R9", "software clear", shutdown_active, 0);
    repeat (4) @(negedge clk);
    chk(pwm_out[0] == 1'b0, "R9", "still forced before boundary", pwm_out[0], 0);
    wait_flag();
    repeat (5) @(negedge clk);
    chk(pwm_out[0] == 1'b1, "R9", "drive resumes after boundary", pwm_out[0], 1);

    // R10 auto-restart
    wr(3'd4, 8'h80);
    fault_in = 3'b001;
    repeat (5) @(negedge clk);
    chk(shutdown_active == 1'b1, "R10", "fault enters shutdown", shutdown_active, 1);
    wait_flag();
    wait_flag();
    chk(shutdown_active == 1'b1, "R10", "held while fault present", shutdown_active, 1);
    fault_in = 3'b000;
    repeat (4) @(negedge clk);
    chk(shutdown_active == 1'b1, "R10", "waits for boundary", shutdown_active, 1);
    wait_flag();
    chk(shutdown_active == 1'b0, "R10", "released at boundary", shutdown_active, 0);
    repeat (5) @(negedge clk);
    chk(pwm_out[0] == 1'b1, "R10", "drive resumes", pwm_out[0], 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule